// File: doc/BRIEF.md
# Active Video Region Detector

This block sits on the sampled pixel stream of a video input path and finds the bounding box of real picture content in each frame. On every sample clock it receives the sync levels and one RGB sample, and compares each 8-bit colour component with a programmable threshold. For the frame in progress it tracks the smallest and largest pixel column and line that hold a qualifying sample.

When a new frame begins, the block copies the four positions into output registers and raises a one-cycle pulse. The outputs therefore always describe the last complete frame. Column zero is the sample on which HSYNC is first seen high after being low. This is the same reference point a source timing generator uses, so a measured start value can be loaded there without correction. Firmware typically reads the box after each pulse to centre or auto-size the picture.

Top module: `vid_extent_meter`

## Requirements
- R1: A sample qualifies when at least one of its red, green or blue components is strictly greater than `thresh_i`. A component equal to the threshold does not qualify.
- R2: The column of a sample is 0 on the clock where `hsync_i` is high and was low on the previous clock. The column increases by one on each following clock.
- R3: The line number is 0 on the clock where `vsync_i` is high and was low on the previous clock. It increases by one on each later HSYNC rising sample, so the first HSYNC after VSYNC starts line 1.
- R4: On the clock after a VSYNC rising sample, the four position outputs hold the extreme columns and lines of the qualifying samples seen since the previous VSYNC rising sample. The frame ends before that rising sample.
- R5: `done_o` is high for exactly one clock after each VSYNC rising sample and low at all other times.
- R6: If the ending frame held no qualifying sample, `found_o` goes low with the pulse and the four position outputs keep their previous values. Otherwise `found_o` goes high.
- R7: Column and line counts saturate at 4095 instead of wrapping.
- R8: After a synchronous active-low reset, all position outputs, `found_o` and `done_o` are 0. Both counts start saturated at 4095, and both syncs count as previously low.
- R9: A qualifying sample on the VSYNC rising clock belongs to the new frame, at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| red_i | input | 8 | Red component of the current sample |
| grn_i | input | 8 | Green component of the current sample |
| blu_i | input | 8 | Blue component of the current sample |
| thresh_i | input | 8 | Qualification threshold |
| col_first_o | output | 12 | First qualifying column of the last frame |
| col_last_o | output | 12 | Last qualifying column of the last frame |
| row_first_o | output | 12 | First qualifying line of the last frame |
| row_last_o | output | 12 | Last qualifying line of the last frame |
| found_o | output | 1 | Last frame held at least one qualifying sample |
| done_o | output | 1 | One-clock pulse when new results are latched |

## Verification
Frames carry a rectangular box whose lit component changes from frame to frame. Samples outside the box are held exactly at the threshold, which separates a strict comparison from a greater-or-equal one and shows that each colour channel is tested. A frame with no content checks that old results are kept. A lit sample placed on the VSYNC rising clock shows which frame an edge sample is assigned to. Very long lines and very tall frames push both counts past 4095 and expose any counter that wraps instead of saturating.

// File: rtl/vem_pkg.sv
// Shared definitions for the active video region detector.
// Assumes: nothing beyond the default widths listed here.
package vem_pkg;
    localparam int unsigned DEF_POS_W = 12;
    localparam int unsigned DEF_PIX_W = 8;
    localparam int unsigned N_COMP    = 3;
    localparam int unsigned N_AXIS    = 2;

    // Axis index used to select per-axis extent trackers.
    typedef enum logic [0:0] {
        AXIS_COL = 1'b0,
        AXIS_ROW = 1'b1
    } axis_e;
endpackage

// File: rtl/vem_sync_edge.sv
// Rising-edge finder for one sync input.
// Assumes: the input is already synchronous to clk. After reset the
// previous level is taken as low, so a sync held high at reset release
// counts as a rising edge.
module vem_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    // Remember last sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    // Rising edge seen in this sample.
    always_comb rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/vem_qualify.sv
// Decides whether one sample carries picture content.
// Assumes: all components share one threshold; strict comparison.
module vem_qualify #(
    parameter int unsigned PIX_W  = vem_pkg::DEF_PIX_W,
    parameter int unsigned N_COMP = vem_pkg::N_COMP
) (
    input  logic [N_COMP-1:0][PIX_W-1:0] comp_i,
    input  logic [PIX_W-1:0]             thresh_i,
    output logic                         hit_o
);
    logic [N_COMP-1:0] above;

    genvar gi;
    generate
        for (gi = 0; gi < N_COMP; gi++) begin : g_cmp
            // Per-component comparison.
            always_comb above[gi] = (comp_i[gi] > thresh_i);
        end
    endgenerate

    // Any component above threshold qualifies the sample.
    always_comb hit_o = |above;
endmodule

// File: rtl/vem_pos_track.sv
// Tracks column and line of the current sample.
// Assumes: the column resets on the HSYNC rising sample and the line
// resets on the VSYNC rising sample. Each HSYNC rise advances the line.
// Both counts saturate at all-ones and start saturated after reset.
module vem_pos_track #(
    parameter int unsigned POS_W = vem_pkg::DEF_POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise_i,
    input  logic             vs_rise_i,
    output logic [POS_W-1:0] col_o,
    output logic [POS_W-1:0] row_o
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] col_q, row_q;

    // Position of the sample presented this cycle.
    always_comb begin
        if (hs_rise_i)             col_o = '0;
        else if (col_q == POS_MAX) col_o = POS_MAX;
        else                       col_o = col_q + 1'b1;

        if (vs_rise_i)                                   row_o = '0;
        else if (hs_rise_i && (row_q != POS_MAX))        row_o = row_q + 1'b1;
        else                                             row_o = row_q;
    end

    // Hold the position for the next sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= POS_MAX;
            row_q <= POS_MAX;
        end else begin
            col_q <= col_o;
            row_q <= row_o;
        end
    end
endmodule

// File: rtl/vem_extent.sv
// Working minimum and maximum for one axis over the frame in progress.
// Assumes: frame_end_i marks the first sample of a new frame. That
// sample seeds the fresh working values when it qualifies.
module vem_extent #(
    parameter int unsigned POS_W = vem_pkg::DEF_POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             frame_end_i,
    output logic [POS_W-1:0] lo_o,
    output logic [POS_W-1:0] hi_o,
    output logic             any_o
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] lo_base, hi_base;
    logic             any_base;

    // Starting point: empty values at a frame boundary, else the current ones.
    always_comb begin
        lo_base  = frame_end_i ? POS_MAX : lo_o;
        hi_base  = frame_end_i ? '0      : hi_o;
        any_base = frame_end_i ? 1'b0    : any_o;
    end

    // Fold a qualifying sample into the working extent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o  <= POS_MAX;
            hi_o  <= '0;
            any_o <= 1'b0;
        end else begin
            lo_o  <= (hit_i && pos_i < lo_base) ? pos_i : lo_base;
            hi_o  <= (hit_i && pos_i > hi_base) ? pos_i : hi_base;
            any_o <= any_base | hit_i;
        end
    end
endmodule

// File: rtl/vid_extent_meter.sv
// Active video region detector top.
// Finds the bounding box of samples above a threshold within each frame.
// It publishes the box of the last complete frame on every VSYNC rise.
// Assumes: sync and pixel inputs are synchronous to clk, and both syncs
// are active high.
module vid_extent_meter #(
    parameter int unsigned POS_W = vem_pkg::DEF_POS_W,
    parameter int unsigned PIX_W = vem_pkg::DEF_PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic [PIX_W-1:0] red_i,
    input  logic [PIX_W-1:0] grn_i,
    input  logic [PIX_W-1:0] blu_i,
    input  logic [PIX_W-1:0] thresh_i,
    output logic [POS_W-1:0] col_first_o,
    output logic [POS_W-1:0] col_last_o,
    output logic [POS_W-1:0] row_first_o,
    output logic [POS_W-1:0] row_last_o,
    output logic             found_o,
    output logic             done_o
);
    import vem_pkg::*;

    logic [1:0] sync_lvl, sync_rise;
    logic       hs_rise, vs_rise;
    logic       hit;
    logic [N_COMP-1:0][PIX_W-1:0] comp;
    logic [POS_W-1:0] col, row;
    logic [N_AXIS-1:0][POS_W-1:0] ax_pos, ax_lo, ax_hi;
    logic [N_AXIS-1:0]            ax_any;

    // Gather sync levels and components into arrays.
    always_comb begin
        sync_lvl = {vsync_i, hsync_i};
        comp     = {blu_i, grn_i, red_i};
        hs_rise  = sync_rise[0];
        vs_rise  = sync_rise[1];
        ax_pos[AXIS_COL] = col;
        ax_pos[AXIS_ROW] = row;
    end

    genvar gs;
    generate
        for (gs = 0; gs < 2; gs++) begin : g_sync
            vem_sync_edge u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .sig_i  (sync_lvl[gs]),
                .rise_o (sync_rise[gs])
            );
        end
    endgenerate

    vem_qualify #(.PIX_W(PIX_W), .N_COMP(N_COMP)) u_qual (
        .comp_i   (comp),
        .thresh_i (thresh_i),
        .hit_o    (hit)
    );

    vem_pos_track #(.POS_W(POS_W)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_rise_i (hs_rise),
        .vs_rise_i (vs_rise),
        .col_o     (col),
        .row_o     (row)
    );

    genvar ga;
    generate
        for (ga = 0; ga < N_AXIS; ga++) begin : g_axis
            vem_extent #(.POS_W(POS_W)) u_ext (
                .clk         (clk),
                .rst_n       (rst_n),
                .hit_i       (hit),
                .pos_i       (ax_pos[ga]),
                .frame_end_i (vs_rise),
                .lo_o        (ax_lo[ga]),
                .hi_o        (ax_hi[ga]),
                .any_o       (ax_any[ga])
            );
        end
    endgenerate

    // Publish the finished frame's box at each VSYNC rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_first_o <= '0;
            col_last_o  <= '0;
            row_first_o <= '0;
            row_last_o  <= '0;
            found_o     <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= vs_rise;
            if (vs_rise) begin
                found_o <= ax_any[AXIS_COL];
                if (ax_any[AXIS_COL]) begin
                    col_first_o <= ax_lo[AXIS_COL];
                    col_last_o  <= ax_hi[AXIS_COL];
                    row_first_o <= ax_lo[AXIS_ROW];
                    row_last_o  <= ax_hi[AXIS_ROW];
                end
            end
        end
    end
endmodule

// File: rtl/vem_checks.sv
// Property checker for vid_extent_meter, attached through bind.
// Assumes: synchronous active-low reset held low at time zero.
module vem_checks #(
    parameter int unsigned POS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vsync_i,
    input logic [POS_W-1:0] col_first_o,
    input logic [POS_W-1:0] col_last_o,
    input logic [POS_W-1:0] row_first_o,
    input logic [POS_W-1:0] row_last_o,
    input logic             found_o,
    input logic             done_o
);
    // R5: the pulse never lasts two clocks.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: results only change when a pulse announces them.
    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(col_first_o) && $stable(col_last_o)
                     && $stable(row_first_o) && $stable(row_last_o) && $stable(found_o)));

    // R5: a pulse follows a sample with VSYNC high.
    assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(vsync_i));

    // R4: a found box is never inverted.
    assert_box_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (col_first_o <= col_last_o && row_first_o <= row_last_o));

    // R6: an empty frame leaves the box untouched.
    assert_empty_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> ($stable(col_first_o) && $stable(col_last_o)
                                  && $stable(row_first_o) && $stable(row_last_o)));
endmodule

bind vid_extent_meter vem_checks #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_i     (vsync_i),
    .col_first_o (col_first_o),
    .col_last_o  (col_last_o),
    .row_first_o (row_first_o),
    .row_last_o  (row_last_o),
    .found_o     (found_o),
    .done_o      (done_o)
);

// File: tb/sim_vid_extent_meter.sv
`timescale 1ns/1ps
module sim_vid_extent_meter;
    localparam int MAXP = 4095;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_i = 1'b0, vsync_i = 1'b0;
    logic [7:0] red_i = '0, grn_i = '0, blu_i = '0, thresh_i = 8'd40;
    logic [11:0] col_first_o, col_last_o, row_first_o, row_last_o;
    logic found_o, done_o;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // Behavioural reference state.
    int m_col, m_row, m_hprev, m_vprev;
    int w_clo, w_chi, w_rlo, w_rhi, w_any;
    int e_cf, e_cl, e_rf, e_rl, e_found, e_done;

    always #2.5 clk = ~clk;

    vid_extent_meter u0 (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i), .thresh_i(thresh_i),
        .col_first_o(col_first_o), .col_last_o(col_last_o),
        .row_first_o(row_first_o), .row_last_o(row_last_o),
        .found_o(found_o), .done_o(done_o)
    );

    task automatic model_reset();
        m_col = MAXP; m_row = MAXP; m_hprev = 0; m_vprev = 0;
        w_clo = MAXP; w_chi = 0; w_rlo = MAXP; w_rhi = 0; w_any = 0;
        e_cf = 0; e_cl = 0; e_rf = 0; e_rl = 0; e_found = 0; e_done = 0;
    endtask

    task automatic model_step(input int hs, input int vs, input int r, input int g, input int b, input int th);
        int hr, vr, hit;
        hr = (hs && !m_hprev);
        vr = (vs && !m_vprev);
        m_col = hr ? 0 : (m_col < MAXP ? m_col + 1 : MAXP);
        if (vr) m_row = 0;
        else if (hr && m_row < MAXP) m_row = m_row + 1;
        hit = (r > th) || (g > th) || (b > th);
        e_done = vr;
        if (vr) begin
            e_found = w_any;
            if (w_any) begin e_cf = w_clo; e_cl = w_chi; e_rf = w_rlo; e_rl = w_rhi; end
            w_clo = MAXP; w_chi = 0; w_rlo = MAXP; w_rhi = 0; w_any = 0;
        end
        if (hit) begin
            if (m_col < w_clo) w_clo = m_col;
            if (m_col > w_chi) w_chi = m_col;
            if (m_row < w_rlo) w_rlo = m_row;
            if (m_row > w_rhi) w_rhi = m_row;
            w_any = 1;
        end
        m_hprev = hs; m_vprev = vs;
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (col_first_o != e_cf || col_last_o != e_cl || row_first_o != e_rf ||
            row_last_o != e_rl || found_o != e_found[0] || done_o != e_done[0]) begin
            n_bad++;
            $display("FAIL %s t=%0t actual cf=%0d cl=%0d rf=%0d rl=%0d found=%0d done=%0d expected cf=%0d cl=%0d rf=%0d rl=%0d found=%0d done=%0d",
                     tag, $time, col_first_o, col_last_o, row_first_o, row_last_o, found_o, done_o,
                     e_cf, e_cl, e_rf, e_rl, e_found, e_done);
        end
    endtask

    // Drive one sample, step the model, then compare after the edge.
    task automatic sample(input int hs, input int vs, input int r, input int g, input int b, input string tag);
        hsync_i = hs[0]; vsync_i = vs[0];
        red_i = r[7:0]; grn_i = g[7:0]; blu_i = b[7:0];
        model_step(hs, vs, r, g, b, int'(thresh_i));
        @(posedge clk); #1;
        compare(tag);
    endtask

    // One frame: two VSYNC clocks, then lines opened by two HSYNC clocks.
    // Box in columns x0..x1, lines y0..y1; comp picks the lit channel.
    task automatic frame(input int lines, input int width, input int x0, input int x1,
                         input int y0, input int y1, input int comp, input int vs_hit, input string tag);
        int th;
        th = int'(thresh_i);
        sample(0, 1, vs_hit ? th + 1 : th, th, th, tag);
        sample(0, 1, th, th, th, tag);
        for (int ln = 1; ln <= lines; ln++) begin
            for (int c = 0; c < width; c++) begin
                int lit, r, g, b;
                lit = (c >= x0 && c <= x1 && ln >= y0 && ln <= y1);
                r = th; g = th; b = th;
                if (lit) begin
                    if (comp == 0) r = th + 1;
                    else if (comp == 1) g = 255;
                    else b = th + 1;
                end
                sample(c < 2, 0, r, g, b, tag);
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare("R8 reset");
        rst_n = 1'b1;
        frame(6, 20, 4, 9, 2, 4, 0, 0, "R2 R3 first frame red");
        frame(6, 20, 3, 15, 1, 6, 1, 0, "R1 R4 green box");
        frame(5, 20, 0, 0, 5, 5, 2, 0, "R1 blue single pixel");
        frame(5, 18, 30, 40, 9, 9, 0, 0, "R6 empty frame");
        frame(5, 18, 30, 40, 9, 9, 0, 0, "R6 second empty");
        thresh_i = 8'd200;
        frame(4, 16, 5, 6, 2, 3, 0, 1, "R9 hit on vsync clock");
        frame(4, 16, 2, 2, 1, 1, 2, 0, "R9 latched next");
        thresh_i = 8'd0;
        frame(1, 4100, 4090, 4099, 1, 1, 0, 0, "R7 column saturation");
        frame(4100, 3, 2, 2, 4098, 4099, 1, 0, "R7 row saturation");
        frame(2, 8, 1, 1, 1, 1, 0, 0, "R4 R5 final latch");
        frame(1, 4, 9, 9, 9, 9, 0, 0, "R5 closing frame");
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule